// File: doc/BRIEF.md
# Conversion Result Limit and Saturation Monitor

This block watches the two result streams of a multi-channel scanning converter and raises sticky per-channel flags. One stream carries each raw conversion as it leaves the converter, tagged with its channel and its resolution. The other carries the final per-channel result after averaging, alignment and sign extension, in 16-bit form. A raw conversion that sits at the bottom or top code of its own resolution marks that channel as saturated, and the flag shows up on the next clock. A final result that meets the programmed window condition marks the channel as out of limits. These hits collect in a hidden shadow register during the scan. They move into the visible flags on the cycle in which the end-of-scan pulse arrives.

Software reaches the thresholds, the compare mode, both flag sets, their masks and their masked views through a small synchronous register bus. Flags are cleared by writing ones to them. A single interrupt line is high while any unmasked flag in either set is high.

Top module: `result_limit_monitor`

## Requirements
- R1: After reset the low threshold (address 0x0) reads 0x0200, the high threshold (address 0x1) reads 0x0E00, the mode (address 0x2, bits 1:0) reads 0, and all flags and masks read 0 with `irq` low.
- R2: The window hit depends on the mode code. Code 0 is below, with result < low. Code 1 is inside, with low <= result < high. Code 2 is above, with high <= result. Code 3 is outside, with result < low or high <= result.
- R3: With `res_signed` high, the result and both thresholds are compared as 16-bit two's complement. With it low, they are compared as unsigned values.
- R4: A window hit is held out of sight until an `eos` pulse. On the edge where `eos` is high, every channel hit since the previous `eos`, including one presented in that same cycle, sets its limit flag (address 0x4). The pending hits are then discarded.
- R5: A raw sample sets its channel's saturation flag (address 0x8) on the next edge when its meaningful bits are all zero or all one. The meaningful bits are 11:0 for `smp_res` 0 or 3, 9:0 for `smp_res` 1, and 7:0 for `smp_res` 2. Bits above the meaningful field are ignored.
- R6: Writing a 1 to a bit of either flag register clears that bit, and writing a 0 leaves it unchanged. A hardware set and a software clear of the same bit on the same edge leave the bit set.
- R7: The masked views (limit at 0x6, saturation at 0xA) read flag AND mask. The masks are at 0x5 and 0x9. `irq` is high exactly while either masked view is nonzero.
- R8: Channels at or above `NCH` do not exist. Samples and results tagged with them set no flag, and their mask bits read back 0.
- R9: Writes to the masked views or to unused addresses change no register, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Raw conversion present |
| smp_chan | input | 4 | Channel of the raw conversion |
| smp_res | input | 2 | Resolution code of the raw conversion |
| smp_code | input | 12 | Raw conversion code, right-aligned |
| res_valid | input | 1 | Final result present |
| res_chan | input | 4 | Channel of the final result |
| res_signed | input | 1 | Final result is two's complement |
| res_data | input | 16 | Final 16-bit result |
| eos | input | 1 | End-of-scan pulse |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Any unmasked flag set |

## Verification
The assertions rely on a few properties of the inputs. A channel tag outside the implemented range must arrive with no other side effect. `eos` must be a single-cycle pulse, so that every new limit flag can be traced to an `eos` one edge earlier. Write strobes must be sampled only on clock edges. The bench respects these limits by driving every input on the falling edge and holding `eos` for exactly one cycle. It also sends out-of-range channel tags only in the test that targets them, and it reads the registers half a cycle after each rising edge.

// File: rtl/result_limit_monitor.sv
module result_limit_monitor #(
  parameter int NCH = 16,
  parameter logic [15:0] LO_INIT = 16'h0200,
  parameter logic [15:0] HI_INIT = 16'h0E00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [3:0]  smp_chan,
  input  logic [1:0]  smp_res,
  input  logic [11:0] smp_code,
  input  logic        res_valid,
  input  logic [3:0]  res_chan,
  input  logic        res_signed,
  input  logic [15:0] res_data,
  input  logic        eos,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam logic [15:0] CH_MASK = 16'((32'd1 << NCH) - 1);
  localparam logic [3:0] A_LO = 4'h0, A_HI = 4'h1, A_MODE = 4'h2,
                         A_RREQ = 4'h4, A_RMSK = 4'h5, A_RVIEW = 4'h6,
                         A_SREQ = 4'h8, A_SMSK = 4'h9, A_SVIEW = 4'hA;

  logic [15:0] thr_lo, thr_hi, rng_req, rng_mask, sat_req, sat_mask, shadow;
  logic [1:0]  mode;
  logic        sat_code, below, at_hi, hit;

  wire wr_ok = bus_sel & bus_wr;

  always_comb begin
    case (smp_res)
      2'd1:    sat_code = (&smp_code[9:0]) | ~(|smp_code[9:0]);
      2'd2:    sat_code = (&smp_code[7:0]) | ~(|smp_code[7:0]);
      default: sat_code = (&smp_code)      | ~(|smp_code);
    endcase
  end

  assign below = res_signed ? ($signed(res_data) < $signed(thr_lo)) : (res_data < thr_lo);
  assign at_hi = res_signed ? ($signed(res_data) >= $signed(thr_hi)) : (res_data >= thr_hi);

  always_comb begin
    case (mode)
      2'd0:    hit = below;
      2'd1:    hit = !below && !at_hi;
      2'd2:    hit = at_hi;
      default: hit = below || at_hi;
    endcase
  end

  wire [15:0] rng_hot = (res_valid && hit) ? ((16'd1 << res_chan) & CH_MASK) : 16'd0;
  wire [15:0] sat_set = (smp_valid && sat_code) ? ((16'd1 << smp_chan) & CH_MASK) : 16'd0;
  wire [15:0] rng_set = eos ? (shadow | rng_hot) : 16'd0;
  wire [15:0] rng_clr = (wr_ok && bus_addr == A_RREQ) ? bus_wdata : 16'd0;
  wire [15:0] sat_clr = (wr_ok && bus_addr == A_SREQ) ? bus_wdata : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lo   <= LO_INIT;
      thr_hi   <= HI_INIT;
      mode     <= 2'd0;
      rng_mask <= '0;
      sat_mask <= '0;
      rng_req  <= '0;
      sat_req  <= '0;
      shadow   <= '0;
    end else begin
      if (wr_ok && bus_addr == A_LO)   thr_lo   <= bus_wdata;
      if (wr_ok && bus_addr == A_HI)   thr_hi   <= bus_wdata;
      if (wr_ok && bus_addr == A_MODE) mode     <= bus_wdata[1:0];
      if (wr_ok && bus_addr == A_RMSK) rng_mask <= bus_wdata & CH_MASK;
      if (wr_ok && bus_addr == A_SMSK) sat_mask <= bus_wdata & CH_MASK;
      shadow  <= eos ? 16'd0 : (shadow | rng_hot);
      rng_req <= (rng_req & ~rng_clr) | rng_set;
      sat_req <= (sat_req & ~sat_clr) | sat_set;
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = thr_lo;
      A_HI:    bus_rdata = thr_hi;
      A_MODE:  bus_rdata = {14'd0, mode};
      A_RREQ:  bus_rdata = rng_req;
      A_RMSK:  bus_rdata = rng_mask;
      A_RVIEW: bus_rdata = rng_req & rng_mask;
      A_SREQ:  bus_rdata = sat_req;
      A_SMSK:  bus_rdata = sat_mask;
      A_SVIEW: bus_rdata = sat_req & sat_mask;
      default: bus_rdata = 16'd0;
    endcase
  end

  assign irq = (|(rng_req & rng_mask)) | (|(sat_req & sat_mask));

  a_r4_limit_only_at_eos: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rng_req & ~$past(rng_req))) |-> $past(eos));

  a_r5_sat_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && sat_code && (32'(smp_chan) < NCH)) |=> sat_req[$past(smp_chan)]);

  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((sat_set & sat_clr) != 16'd0) |=>
      ((sat_req & $past(sat_set & sat_clr)) == $past(sat_set & sat_clr)));

  a_r8_no_ghost_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((rng_req | sat_req | rng_mask | sat_mask) & ~CH_MASK) == 16'd0);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_req == 16'd0 && sat_req == 16'd0) |-> !irq);
endmodule

// File: tb/test_result_limit_monitor.sv
module test_result_limit_monitor;
  localparam int NCH = 12;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, res_valid = 0, res_signed = 0, eos = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] smp_chan = 0, res_chan = 0, bus_addr = 0;
  logic [1:0] smp_res = 0;
  logic [11:0] smp_code = 0;
  logic [15:0] res_data = 0, bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  result_limit_monitor #(.NCH(NCH)) i_result_limit_monitor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_res(smp_res), .smp_code(smp_code), .res_valid(res_valid),
    .res_chan(res_chan), .res_signed(res_signed), .res_data(res_data),
    .eos(eos), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic bit exp_hit(input int m, input logic [15:0] d,
                                 input logic [15:0] lo, input logic [15:0] hi, input bit sg);
    int dv, lv, hv;
    dv = sg ? int'($signed(d))  : int'(d);
    lv = sg ? int'($signed(lo)) : int'(lo);
    hv = sg ? int'($signed(hi)) : int'(hi);
    case (m)
      0: return dv < lv;
      1: return (dv >= lv) && (dv < hv);
      2: return dv >= hv;
      default: return (dv < lv) || (dv >= hv);
    endcase
  endfunction

  task automatic range_trial(input int ch, input logic [15:0] d, input bit sg, input bit exp);
    logic [15:0] v;
    wr(4'h4, 16'hFFFF);
    res_valid = 1; res_chan = 4'(ch); res_data = d; res_signed = sg;
    @(negedge clk);
    res_valid = 0;
    rd(4'h4, v); chk("R4 hidden before eos", v, 16'h0);
    eos = 1; @(negedge clk); eos = 0;
    rd(4'h4, v); chk("R2/R3 window hit", v, exp ? (16'd1 << ch) : 16'd0);
  endtask

  task automatic sat_trial(input int ch, input logic [1:0] r, input logic [11:0] c);
    logic [15:0] v;
    int w;
    bit s;
    logic [11:0] f;
    wr(4'h8, 16'hFFFF);
    w = (r == 2'd1) ? 10 : (r == 2'd2) ? 8 : 12;
    f = c & 12'((1 << w) - 1);
    s = (f == 12'd0) || (f == 12'((1 << w) - 1));
    smp_valid = 1; smp_chan = 4'(ch); smp_res = r; smp_code = c;
    @(negedge clk);
    smp_valid = 0;
    rd(4'h8, v); chk("R5 saturation", v, s ? (16'd1 << ch) : 16'd0);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] uvals [8] = '{16'h0000, 16'h01FF, 16'h0200, 16'h0201, 16'h0DFF, 16'h0E00, 16'h0E01, 16'hFFFF};
    logic [15:0] svals [8] = '{16'h8000, 16'hFEFF, 16'hFF00, 16'hFF01, 16'h0000, 16'h00FF, 16'h0100, 16'h7FFF};
    logic [11:0] codes [8] = '{12'h000, 12'hFFF, 12'h3FF, 12'h0FF, 12'hC00, 12'hF00, 12'h555, 12'h001};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'h0, v); chk("R1 low reset", v, 16'h0200);
    rd(4'h1, v); chk("R1 high reset", v, 16'h0E00);
    rd(4'h2, v); chk("R1 mode reset", v, 16'h0000);
    rd(4'h4, v); chk("R1 limit flags reset", v, 16'h0000);
    rd(4'h8, v); chk("R1 sat flags reset", v, 16'h0000);
    rd(4'h5, v); chk("R1 limit mask reset", v, 16'h0000);
    chk("R1 irq reset", {15'd0, irq}, 16'd0);

    for (int m = 0; m < 4; m++) begin
      wr(4'h2, 16'(m));
      wr(4'h0, 16'h0200); wr(4'h1, 16'h0E00);
      for (int i = 0; i < 8; i++)
        range_trial((m * 8 + i) % NCH, uvals[i], 1'b0, exp_hit(m, uvals[i], 16'h0200, 16'h0E00, 1'b0));
      wr(4'h0, 16'hFF00); wr(4'h1, 16'h0100);
      for (int i = 0; i < 8; i++)
        range_trial((m * 8 + i + 3) % NCH, svals[i], 1'b1, exp_hit(m, svals[i], 16'hFF00, 16'h0100, 1'b1));
    end

    // R4: hit in the same cycle as eos, then eos with no pending hits
    wr(4'h2, 16'd0); wr(4'h0, 16'h0200);
    wr(4'h4, 16'hFFFF);
    res_valid = 1; res_chan = 4'd5; res_data = 16'h0010; res_signed = 0; eos = 1;
    @(negedge clk); res_valid = 0; eos = 0;
    rd(4'h4, v); chk("R4 same-cycle hit", v, 16'h0020);
    wr(4'h4, 16'hFFFF);
    eos = 1; @(negedge clk); eos = 0;
    rd(4'h4, v); chk("R4 shadow emptied", v, 16'h0000);

    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 8; i++)
        sat_trial((r * 8 + i) % NCH, 2'(r), codes[i]);

    // R6 clear and set-beats-clear
    wr(4'h8, 16'hFFFF);
    smp_valid = 1; smp_chan = 4'd3; smp_res = 0; smp_code = 12'hFFF;
    @(negedge clk); smp_valid = 0;
    smp_valid = 1; smp_code = 12'h000;
    wr(4'h8, 16'h0008);
    smp_valid = 0;
    rd(4'h8, v); chk("R6 set beats clear", v, 16'h0008);
    wr(4'h8, 16'h0000);
    rd(4'h8, v); chk("R6 write zero keeps", v, 16'h0008);
    wr(4'h8, 16'h0008);
    rd(4'h8, v); chk("R6 write one clears", v, 16'h0000);

    // R7 masks and irq
    smp_valid = 1; smp_chan = 4'd1; smp_code = 12'h000;
    @(negedge clk); smp_valid = 0;
    chk("R7 irq masked off", {15'd0, irq}, 16'd0);
    rd(4'hA, v); chk("R7 sat view masked", v, 16'h0000);
    wr(4'h9, 16'h0002);
    rd(4'hA, v); chk("R7 sat view", v, 16'h0002);
    chk("R7 irq on sat", {15'd0, irq}, 16'd1);
    wr(4'h8, 16'h0002);
    chk("R7 irq cleared", {15'd0, irq}, 16'd0);
    wr(4'h5, 16'h0001);
    res_valid = 1; res_chan = 4'd0; res_data = 16'h0000; eos = 1;
    @(negedge clk); res_valid = 0; eos = 0;
    rd(4'h6, v); chk("R7 limit view", v, 16'h0001);
    chk("R7 irq on limit", {15'd0, irq}, 16'd1);
    wr(4'h4, 16'hFFFF);

    // R9 writes to views and unused addresses
    wr(4'h6, 16'hFFFF); rd(4'h5, v); chk("R9 view write ignored", v, 16'h0001);
    rd(4'h4, v); chk("R9 view write no flags", v, 16'h0000);
    wr(4'h3, 16'hFFFF); rd(4'h3, v); chk("R9 unused reads zero", v, 16'h0000);
    rd(4'h0, v); chk("R9 unused write no effect", v, 16'h0200);

    // R8 nonexistent channels
    wr(4'h9, 16'hFFFF); rd(4'h9, v); chk("R8 mask width", v, 16'h0FFF);
    smp_valid = 1; smp_chan = 4'd13; smp_res = 0; smp_code = 12'hFFF;
    @(negedge clk); smp_valid = 0;
    rd(4'h8, v); chk("R8 sat ghost channel", v, 16'h0000);
    res_valid = 1; res_chan = 4'd14; res_data = 16'h0000; eos = 1;
    @(negedge clk); res_valid = 0; eos = 0;
    rd(4'h4, v); chk("R8 limit ghost channel", v, 16'h0000);
    chk("R8 irq quiet", {15'd0, irq}, 16'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule